// File: doc/BRIEF.md
# Loop Buffer Fetch Controller

This block routes instruction fetches from a processor either to a large program memory or to a small loop buffer placed beside it. When the loop hardware announces a new hardware loop (its first and last body addresses), the controller copies each body instruction into the loop buffer while the first pass runs from program memory. Later passes are then served from the buffer and program memory is not enabled. Once the loop hardware marks the final pass and its last body instruction has been fetched, fetch returns to program memory. Code outside loops always comes from program memory.

A six-state controller handles this. Three of the states only hand the instruction supply from one source to the other. A per-entry valid tag records which body words the buffer holds. If a buffered pass reaches a body word the buffer never captured (a branch skipped it on the first pass), or leaves the body (a call), the controller falls back to recording. Loop buffer and program memory are external macros with one cycle of read latency. The buffer is addressed by the fetch address minus the loop's first address.

Top module: `loop_buffer_fetch`

## Requirements
- R1: Outside a buffered loop, every fetch enables program memory at the fetch address. The program memory word appears on `instr` with `instr_valid` high and `instr_from_buf` low one cycle after the request.
- R2: During a recording pass, each fetched body instruction is written into the loop buffer one cycle after its request, at index (fetch address minus loop first address). The written data is the word program memory returned.
- R3: On passes after the first, a body fetch whose tag is set is read from the loop buffer. `instr_from_buf` is high one cycle later, and `pm_ce` is low in the request cycle.
- R4: When the final-pass flag is high and the loop's last address is fetched from the buffer, the next fetch goes to program memory, and the controller is idle one cycle after that.
- R5: The controller has six states: idle, hand-over into recording, recording, hand-over into buffer supply, buffer supply, and hand-over back to idle. The hand-over back to idle lasts exactly one cycle.
- R6: In buffer supply, a body fetch whose tag is clear is served from program memory and recorded. Recording then continues until the next fetch of the loop's first address.
- R7: In buffer supply, a fetch outside the loop body is served from program memory, and the controller falls back to recording.
- R8: Announcing a loop clears every valid tag. No word stored for an earlier loop is ever served for the new one.
- R9: A loop whose body is longer than the buffer depth is never recorded. All of its fetches come from program memory and no buffer write occurs.
- R10: The buffer depth is a build parameter of 8, 16, 32 or 64 words. A body of exactly that depth is recorded and served in full.
- R11: A one-instruction body that is read from the buffer in the same cycle its write lands still returns the newly recorded word.
- R12: During and right after reset there is no valid instruction, no buffer write and no program memory enable without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Processor fetch request |
| fetch_addr | input | AW | Fetch address |
| instr | output | IW | Fetched instruction, one cycle after the request |
| instr_valid | output | 1 | `instr` holds a fetched word |
| instr_from_buf | output | 1 | The word came from the loop buffer |
| loop_set | input | 1 | Pulse: a new hardware loop is announced |
| loop_first | input | AW | First body address, sampled with `loop_set` |
| loop_last | input | AW | Last body address, sampled with `loop_set` |
| loop_final | input | 1 | The current pass is the final one |
| pm_ce | output | 1 | Program memory read enable |
| pm_addr | output | AW | Program memory address |
| pm_rdata | input | IW | Program memory read data, one cycle latency |
| lb_re | output | 1 | Loop buffer read enable |
| lb_raddr | output | log2(DEPTH) | Loop buffer read index |
| lb_rdata | input | IW | Loop buffer read data, one cycle latency |
| lb_we | output | 1 | Loop buffer write enable |
| lb_waddr | output | log2(DEPTH) | Loop buffer write index |
| lb_wdata | output | IW | Loop buffer write data |

## Verification
Fetch streams for several loop shapes go through the controller. A straight four-word loop separates first-pass recording from buffer supply and from the return at the final pass. A loop whose first pass skips two body words shows whether tags were cleared and whether a missing tag forces re-recording. A one-word loop exercises the read that lands in the same cycle as its write. A pass that leaves the body through a call, a body one word too long, and a body exactly as long as the buffer cover the fallback, the refusal to record, and the top index. Every returned word is compared with the program memory contents, along with the reported source and the memory enable.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // fetch from program memory, nothing recorded
    ST_ARM  = 3'd1,  // hand-over into recording
    ST_REC  = 3'd2,  // recording the first pass
    ST_HAND = 3'd3,  // hand-over into buffer supply
    ST_SUP  = 3'd4,  // buffer supplies the body
    ST_EXIT = 3'd5   // hand-over back to program memory
  } lbf_state_e;

endpackage

// File: rtl/lbf_tags.sv
module lbf_tags #(
  parameter int DEPTH = 16,
  localparam int XW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set,
  input  logic [XW-1:0] set_idx,
  input  logic [XW-1:0] rd_idx,
  output logic          hit
);

  logic [DEPTH-1:0] tag_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst || clr)
        tag_q[i] <= 1'b0;
      else if (set && set_idx == XW'(i))
        tag_q[i] <= 1'b1;
    end
  end

  assign hit = tag_q[rd_idx];

  // R8: an announcement leaves no tag set
  a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tag_q == '0));

endmodule

// File: rtl/lbf_ctrl.sv
module lbf_ctrl
  import lbf_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 16,
  localparam int XW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  input  logic          loop_set,
  input  logic [AW-1:0] loop_first,
  input  logic [AW-1:0] loop_last,
  input  logic          loop_final,
  input  logic          tag_hit,
  output logic [XW-1:0] idx,
  output logic          use_buf,
  output logic          rec,
  output logic          tag_clr,
  output logic          pm_ce
);

  lbf_state_e st_q, st_d;
  logic [AW-1:0] first_q, last_q;
  logic in_body, at_first, at_last, fits;

  assign fits     = (loop_last >= loop_first) &&
                    ((loop_last - loop_first) <= AW'(DEPTH - 1));
  assign in_body  = (fetch_addr >= first_q) && (fetch_addr <= last_q);
  assign at_first = (fetch_addr == first_q);
  assign at_last  = (fetch_addr == last_q);
  assign idx      = XW'(fetch_addr - first_q);
  assign tag_clr  = loop_set;

  always_comb begin
    st_d    = st_q;
    use_buf = 1'b0;
    rec     = 1'b0;
    unique case (st_q)
      ST_IDLE: ;
      ST_ARM, ST_REC: begin
        if (fetch_req && in_body) begin
          rec = 1'b1;
          if (st_q == ST_ARM && at_first && !at_last)
            st_d = ST_REC;
          else if ((st_q == ST_REC || at_first) && at_last)
            st_d = loop_final ? ST_EXIT : ST_HAND;
        end
      end
      ST_HAND, ST_SUP: begin
        if (fetch_req) begin
          if (in_body && tag_hit) begin
            use_buf = 1'b1;
            if (at_last && loop_final)
              st_d = ST_EXIT;
            else
              st_d = ST_SUP;
          end else begin
            rec  = in_body;
            st_d = ST_ARM;
          end
        end
      end
      ST_EXIT: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (loop_set) begin
      use_buf = 1'b0;
      rec     = 1'b0;
      st_d    = fits ? ST_ARM : ST_IDLE;
    end
  end

  assign pm_ce = fetch_req && !use_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      st_q <= st_d;
      if (loop_set) begin
        first_q <= loop_first;
        last_q  <= loop_last;
      end
    end
  end

  // R3: a buffer-served fetch never touches program memory
  a_r3_buf_no_pm: assert property (@(posedge clk) disable iff (rst)
    use_buf |-> !pm_ce);

  // R5: the hand-over back to idle lasts one cycle
  a_r5_exit_once: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXIT && !loop_set) |=> (st_q == ST_IDLE));

  // R4: final pass ending in the buffer hands back to program memory
  a_r4_final_exit: assert property (@(posedge clk) disable iff (rst)
    (use_buf && at_last && loop_final) |=> (st_q == ST_EXIT));

  // R9: nothing is recorded while idle
  a_r9_idle_no_rec: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !rec);

  // R10: only the supported depths are built
  initial begin
    a_r10_depth: assert (DEPTH == 8 || DEPTH == 16 || DEPTH == 32 || DEPTH == 64);
  end

endmodule

// File: rtl/lbf_out.sv
module lbf_out #(
  parameter int IW    = 32,
  parameter int DEPTH = 16,
  localparam int XW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_req,
  input  logic          use_buf,
  input  logic          rec,
  input  logic [XW-1:0] idx,
  input  logic [IW-1:0] pm_rdata,
  input  logic [IW-1:0] lb_rdata,
  output logic [IW-1:0] instr,
  output logic          instr_valid,
  output logic          instr_from_buf,
  output logic          lb_we,
  output logic [XW-1:0] lb_waddr,
  output logic [IW-1:0] lb_wdata
);

  logic          vld_q, buf_q, rec_q, fwd_q;
  logic [XW-1:0] widx_q;
  logic [IW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      buf_q  <= 1'b0;
      rec_q  <= 1'b0;
      fwd_q  <= 1'b0;
      widx_q <= '0;
      hold_q <= '0;
    end else begin
      vld_q  <= fetch_req;
      buf_q  <= use_buf;
      rec_q  <= rec;
      widx_q <= idx;
      // a read issued while the same entry is being written sees old data
      fwd_q  <= use_buf && rec_q && (idx == widx_q);
      hold_q <= pm_rdata;
    end
  end

  assign instr          = !buf_q ? pm_rdata : (fwd_q ? hold_q : lb_rdata);
  assign instr_valid    = vld_q;
  assign instr_from_buf = buf_q;
  assign lb_we          = rec_q;
  assign lb_waddr       = widx_q;
  assign lb_wdata       = pm_rdata;

  // R2: a recorded fetch is written one cycle later
  a_r2_write_follows: assert property (@(posedge clk) disable iff (rst)
    rec |=> lb_we);

  // R1: every request yields a word one cycle later
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> instr_valid);

  // R12: no word without a request
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !fetch_req |=> !instr_valid);

endmodule

// File: rtl/loop_buffer_fetch.sv
module loop_buffer_fetch #(
  parameter int AW    = 12,
  parameter int IW    = 32,
  parameter int DEPTH = 16,
  localparam int XW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  output logic [IW-1:0] instr,
  output logic          instr_valid,
  output logic          instr_from_buf,
  input  logic          loop_set,
  input  logic [AW-1:0] loop_first,
  input  logic [AW-1:0] loop_last,
  input  logic          loop_final,
  output logic          pm_ce,
  output logic [AW-1:0] pm_addr,
  input  logic [IW-1:0] pm_rdata,
  output logic          lb_re,
  output logic [XW-1:0] lb_raddr,
  input  logic [IW-1:0] lb_rdata,
  output logic          lb_we,
  output logic [XW-1:0] lb_waddr,
  output logic [IW-1:0] lb_wdata
);

  logic [XW-1:0] idx;
  logic use_buf, rec, tag_clr, tag_hit;

  lbf_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .loop_set(loop_set), .loop_first(loop_first),
    .loop_last(loop_last), .loop_final(loop_final),
    .tag_hit(tag_hit), .idx(idx), .use_buf(use_buf),
    .rec(rec), .tag_clr(tag_clr), .pm_ce(pm_ce)
  );

  lbf_tags #(.DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst(rst), .clr(tag_clr), .set(rec),
    .set_idx(idx), .rd_idx(idx), .hit(tag_hit)
  );

  lbf_out #(.IW(IW), .DEPTH(DEPTH)) u_out (
    .clk(clk), .rst(rst), .fetch_req(fetch_req),
    .use_buf(use_buf), .rec(rec), .idx(idx),
    .pm_rdata(pm_rdata), .lb_rdata(lb_rdata),
    .instr(instr), .instr_valid(instr_valid),
    .instr_from_buf(instr_from_buf), .lb_we(lb_we),
    .lb_waddr(lb_waddr), .lb_wdata(lb_wdata)
  );

  assign pm_addr  = fetch_addr;
  assign lb_re    = use_buf;
  assign lb_raddr = idx;

endmodule

// File: tb/loop_buffer_fetch_test.sv
module loop_buffer_fetch_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int IW = 32;
  localparam int DEPTH = 16;
  localparam int XW = $clog2(DEPTH);
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [IW-1:0] instr;
  logic instr_valid, instr_from_buf;
  logic loop_set = 1'b0;
  logic [AW-1:0] loop_first = '0, loop_last = '0;
  logic loop_final = 1'b0;
  logic pm_ce;
  logic [AW-1:0] pm_addr;
  logic [IW-1:0] pm_rdata = '0;
  logic lb_re;
  logic [XW-1:0] lb_raddr;
  logic [IW-1:0] lb_rdata = '0;
  logic lb_we;
  logic [XW-1:0] lb_waddr;
  logic [IW-1:0] lb_wdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wr_count = 0;
  bit done = 0;

  logic [IW-1:0] lbm [DEPTH];

  typedef struct {
    logic [IW-1:0] w;
    logic          b;
    string         r;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_buffer_fetch #(.AW(AW), .IW(IW), .DEPTH(DEPTH)) uut (.*);

  function automatic logic [IW-1:0] word_at(input logic [AW-1:0] a);
    return (IW'(a) * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction

  // memory models: one cycle of read latency, read-before-write
  always @(posedge clk) if (pm_ce) pm_rdata <= word_at(pm_addr);
  always @(posedge clk) begin
    if (lb_re) lb_rdata <= lbm[lb_raddr];
    if (lb_we) lbm[lb_waddr] <= lb_wdata;
  end

  task automatic check(input bit ok, input string r, input string what,
                       input logic [IW-1:0] act, input logic [IW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // monitor: pops expected words as the design returns them
  always @(negedge clk) begin
    if (!rst) begin
      if (lb_we) wr_count++;
      if (instr_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R12", "word with no request", instr, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(instr == e.w, e.r, "instr", instr, e.w);
          check(instr_from_buf == e.b, e.r, "source", IW'(instr_from_buf), IW'(e.b));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic fetch(input logic [AW-1:0] a, input bit from_buf,
                       input bit fin, input string r);
    exp_t e;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    loop_final = fin;
    e.w = word_at(a);
    e.b = from_buf;
    e.r = r;
    sb.push_back(e);
    #1;
    check(pm_ce == !from_buf, r, "pm_ce", IW'(pm_ce), IW'(!from_buf));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetch_req  = 1'b0;
      loop_final = 1'b0;
    end
  endtask

  task automatic announce(input logic [AW-1:0] f, input logic [AW-1:0] l);
    @(negedge clk);
    fetch_req  = 1'b0;
    loop_set   = 1'b1;
    loop_first = f;
    loop_last  = l;
    @(negedge clk);
    loop_set   = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) lbm[i] = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!instr_valid, "R12", "valid in reset", IW'(instr_valid), '0);
    check(!lb_we, "R12", "write in reset", IW'(lb_we), '0);
    check(!pm_ce, "R12", "pm_ce in reset", IW'(pm_ce), '0);
    rst = 1'b0;
    @(negedge clk);
    check(!instr_valid && !lb_we, "R12", "after reset", IW'({instr_valid, lb_we}), '0);

    // R1: straight-line code
    for (int a = 'h010; a < 'h014; a++) fetch(AW'(a), 0, 0, "R1");
    idle(2);

    // Loop A: 0x100..0x103, three passes
    announce(AW'('h100), AW'('h103));
    for (int a = 'h100; a <= 'h103; a++) fetch(AW'(a), 0, 0, "R2");
    for (int a = 'h100; a <= 'h103; a++) fetch(AW'(a), 1, 0, "R3");
    for (int a = 'h100; a <= 'h103; a++) fetch(AW'(a), 1, 1, "R3");
    fetch(AW'('h104), 0, 0, "R4");
    fetch(AW'('h105), 0, 0, "R5");
    idle(2);
    for (int i = 0; i < 4; i++)
      check(lbm[i] == word_at(AW'('h100 + i)), "R2", "buffer content", lbm[i], word_at(AW'('h100 + i)));

    // Footprint change: 0x400..0x405, first pass skips 0x402/0x403
    announce(AW'('h400), AW'('h405));
    fetch(AW'('h400), 0, 0, "R2");
    fetch(AW'('h401), 0, 0, "R2");
    fetch(AW'('h404), 0, 0, "R2");
    fetch(AW'('h405), 0, 0, "R2");
    fetch(AW'('h400), 1, 0, "R3");
    fetch(AW'('h401), 1, 0, "R3");
    fetch(AW'('h402), 0, 0, "R6,R8");   // stale tag from loop A would hit here
    fetch(AW'('h403), 0, 0, "R6");
    fetch(AW'('h404), 0, 0, "R6");
    fetch(AW'('h405), 0, 0, "R6");
    for (int a = 'h400; a <= 'h405; a++) fetch(AW'(a), 0, 0, "R6");
    for (int a = 'h400; a <= 'h405; a++) fetch(AW'(a), 1, 1, "R6");
    fetch(AW'('h406), 0, 0, "R4");
    idle(2);
    check(lbm[2] == word_at(AW'('h402)), "R6", "re-recorded word", lbm[2], word_at(AW'('h402)));

    // One-word body: read collides with its own write
    announce(AW'('h200), AW'('h200));
    fetch(AW'('h200), 0, 0, "R2");
    fetch(AW'('h200), 1, 0, "R11");
    fetch(AW'('h200), 1, 1, "R11");
    fetch(AW'('h201), 0, 0, "R4");
    idle(2);

    // Body one word longer than the buffer
    wr_count = 0;
    announce(AW'('h300), AW'('h300 + DEPTH));
    for (int p = 0; p < 2; p++)
      for (int a = 'h300; a <= 'h300 + DEPTH; a++) fetch(AW'(a), 0, p == 1, "R9");
    idle(2);
    check(wr_count == 0, "R9", "writes for oversize body", IW'(wr_count), '0);

    // Call out of the body during buffer supply
    announce(AW'('h500), AW'('h502));
    for (int a = 'h500; a <= 'h502; a++) fetch(AW'(a), 0, 0, "R2");
    fetch(AW'('h500), 1, 0, "R3");
    fetch(AW'('h501), 1, 0, "R3");
    fetch(AW'('h600), 0, 0, "R7");
    fetch(AW'('h601), 0, 0, "R7");
    fetch(AW'('h502), 0, 0, "R7");
    for (int a = 'h500; a <= 'h502; a++) fetch(AW'(a), 0, 1, "R7");
    fetch(AW'('h503), 0, 0, "R4");
    idle(2);

    // Body exactly as deep as the buffer
    announce(AW'('h800), AW'('h800 + DEPTH - 1));
    for (int a = 'h800; a < 'h800 + DEPTH; a++) fetch(AW'(a), 0, 0, "R10");
    for (int a = 'h800; a < 'h800 + DEPTH; a++) fetch(AW'(a), 1, 1, "R10");
    fetch(AW'('h800 + DEPTH), 0, 0, "R10");
    idle(3);

    check(sb.size() == 0, "R1", "words never returned", IW'(sb.size()), '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule